// File: doc/BRIEF.md
# Two-Channel Serial Audio Transmitter

This block shifts pairs of 24-bit two's-complement samples out on one serial data line, most significant bit first. Bit clock and word clock come from outside. Both are sampled in the block's system clock domain, which must run well above the bit clock. A falling bit-clock edge moves the line to its next bit. A transition of the word clock seen at that same edge opens a new half-frame. Two half-frame lengths work: 24 bit slots (a 48-slot frame with no padding) and 32 bit slots (a 64-slot frame in which every slot past the sample is driven low).

The framing format is not set by an input. On the first clock after reset is released, the block reads the level of its own data pin while the pin driver is still off. An external pull-up on that pin selects I2S framing and a pull-down selects left-justified framing. The driver is enabled from then on.

The producer offers a left/right pair with a valid/ready handshake, and the pair goes into a one-entry holding register. That pair moves to the shifter at the word-clock edge that opens the left half. If no pair is waiting at that edge, the pair already in the shifter is sent again.

Top module: `aud_ser_tx`

## Requirements
- R1: `sdout_oe_o` is low while `rst_n` is low and on the first clock after release, and high from the second clock after release onward.
- R2: The level on `sdout_i` on the first clock after reset release sets the format: 1 selects I2S, 0 selects left-justified. The format then stays fixed until the next reset.
- R3: Each channel is sent as 24 bits of two's complement, bit 23 first and bit 0 last.
- R4: Left-justified: the left sample occupies the half in which `lrck_i` is 1. Bit 23 is in the slot that starts at the `lrck_i` transition, so slot k of a half carries bit 23-k.
- R5: I2S: the left sample occupies the half in which `lrck_i` is 0. Bit 23 is in slot 1, one bit clock after the transition, so slot k (k from 1 to 24) carries bit 24-k.
- R6: I2S with 24-slot halves: slot 0 of each half carries bit 0 of the word from the preceding half. This holds only when the preceding half was exactly 24 slots long. Otherwise slot 0 is 0.
- R7: Slots of a half that carry no sample bit (slots 24 to 31 left-justified, slots 25 to 31 I2S, in 32-slot halves) are driven 0.
- R8: `pair_ready_o` is high when the holding register is empty. A pair taken with `pair_valid_i`&&`pair_ready_o` makes ready fall on the next clock. The pair is loaded, and ready rises again, at the edge that opens the left half.
- R9: When no pair is waiting at a left-half edge, the previous left and right samples are sent again unchanged.
- R10: `sdout_o` changes only on the clock after a detected falling edge of `sclk_i`. It holds steady while `sclk_i` stays high.
- R11: After reset, `sdout_o` stays 0 until the first `lrck_i` transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Bit clock, synchronous to clk |
| lrck_i | input | 1 | Word clock, changes at bit-clock falling edges |
| pair_valid_i | input | 1 | A sample pair is offered |
| pair_ready_o | output | 1 | Holding register empty, pair accepted |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| sdout_i | input | 1 | Level read back from the data pin |
| sdout_o | output | 1 | Serial data out |
| sdout_oe_o | output | 1 | Data pin driver enable |

## Verification
The bench builds the block with its default parameters: a 24-bit word and a 6-bit slot counter. It drives a bit clock that takes eight system clocks per period. Those values let it run both half-frame lengths in both strap-selected formats, including 24-slot I2S halves, where a sample's last bit falls into the next half. It also covers pairs that arrive on time, frames with no new pair, and the quiet output before the first word-clock transition.

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              lrck_i,
  input  logic              pair_valid_i,
  output logic              pair_ready_o,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              sdout_i,
  output logic              sdout_o,
  output logic              sdout_oe_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic              strapped, fmt_i2s, synced, full;
  logic              sclk_d, lrck_q, sdout_q;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] hold_l, hold_r, cur_l, cur_r;

  logic              fall, lr_edge, left_now, load;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [WORD_W-1:0] nxt_l, nxt_r, word_now, prev_word;
  logic              bit_n;

  assign fall      = strapped & sclk_d & ~sclk_i;
  assign lr_edge   = lrck_i ^ lrck_q;
  assign left_now  = lrck_i ^ fmt_i2s;
  assign load      = fall & lr_edge & left_now & full;
  assign nxt_l     = load ? hold_l : cur_l;
  assign nxt_r     = load ? hold_r : cur_r;
  assign word_now  = left_now ? nxt_l : nxt_r;
  assign prev_word = left_now ? cur_r : cur_l;
  assign cnt_nxt   = lr_edge ? '0 : ((cnt == CNT_MAX) ? cnt : cnt + 1'b1);

  always_comb begin
    int k;
    k = int'(cnt_nxt);
    bit_n = 1'b0;
    if (!fmt_i2s) begin
      if (k < WORD_W) bit_n = word_now[WORD_W-1-k];
    end else if (k == 0) begin
      bit_n = synced & (cnt == LAST_IDX) & prev_word[0];
    end else if (k <= WORD_W) begin
      bit_n = word_now[WORD_W-k];
    end
    if (!(synced | lr_edge)) bit_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strapped <= 1'b0;
      fmt_i2s  <= 1'b0;
      synced   <= 1'b0;
      sclk_d   <= 1'b0;
      lrck_q   <= 1'b0;
      sdout_q  <= 1'b0;
      cnt      <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
    end else begin
      sclk_d <= sclk_i;
      if (!strapped) begin
        strapped <= 1'b1;
        fmt_i2s  <= sdout_i;
        lrck_q   <= lrck_i;
      end else if (fall) begin
        lrck_q  <= lrck_i;
        cnt     <= cnt_nxt;
        sdout_q <= bit_n;
        cur_l   <= nxt_l;
        cur_r   <= nxt_r;
        if (lr_edge) synced <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
    end else if (load) begin
      full <= 1'b0;
    end else if (pair_valid_i && pair_ready_o) begin
      full   <= 1'b1;
      hold_l <= left_i;
      hold_r <= right_i;
    end
  end

  assign pair_ready_o = strapped & ~full;
  assign sdout_o      = sdout_q;
  assign sdout_oe_o   = strapped;
endmodule

module aud_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_i,
  input logic pair_valid_i,
  input logic pair_ready_o,
  input logic sdout_o,
  input logic sdout_oe_o,
  input logic fmt_i2s,
  input logic synced
);
  // R1
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdout_oe_o |=> sdout_oe_o);
  // R1
  oe_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdout_oe_o) |-> $past(rst_n));
  // R2
  fmt_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdout_oe_o && $past(sdout_oe_o)) |-> $stable(fmt_i2s));
  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid_i && pair_ready_o) |=> !pair_ready_o);
  // R10
  sdout_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_i && $past(sclk_i)) |-> $stable(sdout_o));
  // R11
  quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !sdout_o);
endmodule

bind aud_ser_tx aud_ser_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .pair_valid_i(pair_valid_i),
  .pair_ready_o(pair_ready_o), .sdout_o(sdout_o), .sdout_oe_o(sdout_oe_o),
  .fmt_i2s(fmt_i2s), .synced(synced)
);

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, lrck = 1'b0;
  logic valid = 1'b0, strap_lvl = 1'b0;
  logic [23:0] lw = '0, rw = '0;
  logic ready, sdout, oe, pin;
  int checks = 0, fails = 0;

  logic [23:0] cur_l, cur_r, pend_l, pend_r;
  logic pend_v, i2s;
  int prev_len;

  always #2.5 clk = ~clk;
  assign pin = oe ? sdout : strap_lvl;

  aud_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .lrck_i(lrck),
    .pair_valid_i(valid), .pair_ready_o(ready), .left_i(lw), .right_i(rw),
    .sdout_i(pin), .sdout_o(sdout), .sdout_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit fmt);
    i2s = fmt;
    strap_lvl = fmt;
    rst_n = 1'b0;
    sclk = 1'b1;
    lrck = fmt ? 1'b1 : 1'b0;
    repeat (4) @(negedge clk);
    chk(oe == 1'b0, "R1 oe in reset", {63'd0, oe}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(oe == 1'b1, "R1 oe after release", {63'd0, oe}, 64'd1);
    chk(ready == 1'b1, "R8 ready empty", {63'd0, ready}, 64'd1);
    cur_l = '0; cur_r = '0; pend_v = 1'b0; prev_len = 3;
    for (int s = 0; s < 3; s++) begin
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      chk(sdout == 1'b0, "R11 quiet before first edge", {63'd0, sdout}, 64'd0);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    while (!ready) @(negedge clk);
    lw = l; rw = r; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(ready == 1'b0, "R8 ready low after take", {63'd0, ready}, 64'd0);
    pend_l = l; pend_r = r; pend_v = 1'b1;
  endtask

  function automatic logic exp_bit(input int k, input int half, input logic [23:0] w,
                                   input logic [23:0] pw, input int plen);
    if (!i2s) return (k < 24) ? w[23-k] : 1'b0;
    if (k == 0) return (plen == 24) ? pw[0] : 1'b0;
    return (k <= 24) ? w[24-k] : 1'b0;
  endfunction

  task automatic frame(input int half, input string tag);
    logic [63:0] got, exp;
    logic a, b;
    bit stable;
    logic left_lvl;
    left_lvl = i2s ? 1'b0 : 1'b1;
    if (pend_v) begin cur_l = pend_l; cur_r = pend_r; pend_v = 1'b0; end
    for (int h = 0; h < 2; h++) begin
      got = '0; exp = '0; stable = 1'b1;
      for (int k = 0; k < half; k++) begin
        lrck = (h == 0) ? left_lvl : ~left_lvl;
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        a = sdout;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        b = sdout;
        if (a !== b) stable = 1'b0;
        got[k] = a;
        exp[k] = (h == 0) ? exp_bit(k, half, cur_l, cur_r, prev_len)
                          : exp_bit(k, half, cur_r, cur_l, half);
      end
      chk(got == exp, h == 0 ? {tag, " left half"} : {tag, " right half"}, got, exp);
      chk(stable, "R10 steady while sclk high", {63'd0, stable}, 64'd1);
      if (h == 0) chk(ready == 1'b1, "R8 ready after left edge", {63'd0, ready}, 64'd1);
    end
    prev_len = half;
  endtask

  task automatic t_left_justified();
    do_reset(1'b0);
    push(24'h800001, 24'h7FFFFE);
    frame(24, "R3 R4 lj48");
    push(24'hA5C3F0, 24'h0F0F0F);
    frame(24, "R4 lj48 second");
    frame(24, "R9 lj48 repeat");
    push(24'h123457, 24'hFEDCBA);
    frame(32, "R7 lj64");
  endtask

  task automatic t_i2s();
    do_reset(1'b1);
    push(24'hC00003, 24'h3FFFFD);
    frame(24, "R2 R5 i2s48");
    push(24'h5A5A5B, 24'h000001);
    frame(24, "R6 i2s48 lsb carry");
    frame(24, "R9 i2s48 repeat");
    push(24'h89ABCD, 24'hFFFFFF);
    frame(32, "R7 i2s64");
    frame(32, "R6 i2s64 no carry");
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_left_justified();
    t_i2s();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule